// File: doc/BRIEF.md
# Bus-Snooping Hotspot Queue Feeder

This block sits passively on the address and data bus of a small 8-bit console, on the cartridge side. It watches every CPU access and recognises reads that fall into the video chip's decode space at the two low-nibble offsets that chip ignores on reads. Each such offset, together with three mirrored address bits, names one of sixteen queues. On a matching read the block places the next entry of that queue on the six low data lines and advances the queue's read pointer. The top two data lines are left to the video chip, which drives them on every read in its space.

A kernel can therefore pull a stream of graphics or audio bytes with a single zero-page load and no pointer upkeep. A host-side load port fills the queue storage, rewinds any queue to its first entry and picks, per queue, between a six-bit payload and a four-bit payload that suits volume streaming. The block never drives the address bus and never enables an output during a CPU write.

Bus inputs are sampled on the block's own fast clock. An output enable appears two clock edges after the phase clock rises and is gated off as soon as the phase clock falls or the R/W line shows a write.

Top module: `hotspot_feeder`

## Requirements
- R1: An access is a hotspot read when R/W is 1, address bit 12 is 0, address bit 7 is 0 and address bits 3..1 are all 1 (low nibble E or F). Address bits 11..8 are ignored. The queue number is {A6, A5, A4, A0}.
- R2: Each hotspot read returns the entry at the queue's read pointer and then adds one to that pointer. There are 256 entries per queue, and the pointer wraps from 255 back to 0.
- R3: The output enables for data bits 7 and 6 are never set, and data outputs 7 and 6 always read 0.
- R4: While R/W is 0 (write), no output enable is set. A write to a hotspot address leaves the pointer unchanged.
- R5: Output enables for bits 5..0 become active on the second clock edge after the phase clock is seen high on a hotspot read. They drop at once when the phase clock goes low.
- R6: Reads with A12=1, reads with A7=1, and reads in the video space whose low nibble is not E or F produce no output enable and no pointer change.
- R7: A queue in four-bit mode (mode bit 1) presents entry bits 3..0 on data bits 3..0 and drives data bits 5 and 4 low with their enables on. In mode 0 all six entry bits are presented on bits 5..0.
- R8: A host load writes host_data into entry host_idx of queue host_q. A host clear sets that queue's pointer to 0. A host mode write sets that queue's mode bit.
- R9: When a host load, clear or mode write targets the queue whose hotspot read is being taken in the same clock, the host operation is dropped. A host operation on any other queue takes effect.
- R10: A queue advances exactly once per high phase of the phase clock, however long that phase lasts.
- R11: After reset all pointers are 0, all queues are in six-bit mode and all output enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | CPU address bus |
| bus_rnw | input | 1 | CPU R/W line, 1 = read |
| bus_phi2 | input | 1 | CPU phase clock, high during the data phase |
| bus_dout | output | 8 | Data presented to the bus |
| bus_doe | output | 8 | Per-bit output enable for bus_dout |
| host_wr | input | 1 | Host entry write strobe |
| host_clr | input | 1 | Host pointer clear strobe |
| host_mode_wr | input | 1 | Host mode write strobe |
| host_mode | input | 1 | Mode value for host_mode_wr, 1 = four-bit |
| host_q | input | 4 | Queue addressed by the host |
| host_idx | input | 8 | Entry index for host_wr |
| host_data | input | 6 | Entry value for host_wr |

## Verification
A pointer that is off by one, or that steps twice in one long phase, does not show on the read that causes it. It shows on the next hotspot read of the same queue, as a neighbouring entry, so the bench reads every queue in sequences and compares each result with the entry a model pointer picks. A faulty decode shows on the first access: either an enable appears where none should, or a later read of the aliased queue returns an entry one step too far. Collision and wrap faults surface only one read later, or after a full lap of 256 reads, and the bench covers both.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    localparam int HSQ_ADDR_W   = 13;
    localparam int HSQ_DATA_W   = 8;
    localparam int HSQ_ENTRY_W  = 6;
    localparam int HSQ_NIB_W    = 4;
    localparam int HSQ_NQ_LG    = 4;
    localparam int HSQ_DEPTH_LG = 8;

    typedef enum logic {
        LANE_WIDE   = 1'b0,
        LANE_NIBBLE = 1'b1
    } lane_mode_e;

    // Video chip select: A12 low and A7 low; hotspots sit at low nibble E/F.
    function automatic logic hotspot_addr(input logic [HSQ_ADDR_W-1:0] a);
        return (a[12] == 1'b0) && (a[7] == 1'b0) && (a[3:1] == 3'b111);
    endfunction

    // Queue number from the mirrored bits that still differ between hotspots.
    function automatic logic [HSQ_NQ_LG-1:0] hotspot_queue(input logic [HSQ_ADDR_W-1:0] a);
        return {a[6:4], a[0]};
    endfunction

    typedef struct packed {
        logic                 start;
        logic [HSQ_NQ_LG-1:0] q;
    } hit_t;

    typedef struct packed {
        logic                    wr;
        logic                    clr;
        logic                    mode_wr;
        lane_mode_e              mode;
        logic [HSQ_NQ_LG-1:0]    q;
        logic [HSQ_DEPTH_LG-1:0] idx;
        logic [HSQ_ENTRY_W-1:0]  data;
    } host_op_t;

endpackage

// File: rtl/hsq_snoop.sv
module hsq_snoop
    import hsq_pkg::*;
#(
    parameter int ADDR_W = HSQ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_phi2,
    output hit_t              hit,
    output logic              drive_on
);

    logic [ADDR_W-1:0] s_addr;
    logic              s_rnw;
    logic              s_phi2;
    logic              p_phi2;
    logic              in_spot;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^s_addr[11:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            s_addr <= '0;
            s_rnw  <= 1'b1;
            s_phi2 <= 1'b0;
            p_phi2 <= 1'b0;
        end else begin
            s_addr <= bus_addr;
            s_rnw  <= bus_rnw;
            s_phi2 <= bus_phi2;
            p_phi2 <= s_phi2;
        end
    end

    assign in_spot   = s_rnw && hotspot_addr(s_addr);
    assign hit.start = in_spot && s_phi2 && !p_phi2;
    assign hit.q     = hotspot_queue(s_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_on <= 1'b0;
        end else if (hit.start) begin
            drive_on <= 1'b1;
        end else if (!(in_spot && s_phi2)) begin
            drive_on <= 1'b0;
        end
    end

    // R10
    r10_one_start_chk: assert property (@(posedge clk) disable iff (rst)
        hit.start |=> !hit.start);

    // R5
    r5_drive_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_on) |-> $past(hit.start));

endmodule

// File: rtl/hsq_store.sv
module hsq_store
    import hsq_pkg::*;
#(
    parameter int NQ_LG    = HSQ_NQ_LG,
    parameter int DEPTH_LG = HSQ_DEPTH_LG,
    parameter int ENTRY_W  = HSQ_ENTRY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  hit_t               hit,
    input  host_op_t           host,
    output logic [ENTRY_W-1:0] rd_entry,
    output lane_mode_e         rd_mode
);

    localparam int NQ    = 1 << NQ_LG;
    localparam int DEPTH = 1 << DEPTH_LG;
    localparam int WORDS = NQ * DEPTH;

    logic [ENTRY_W-1:0]  mem [WORDS];
    logic [DEPTH_LG-1:0] ptr [NQ];
    logic [NQ-1:0]       mode_r;
    logic                blocked;

    // CPU read wins: host operations on the queue being read are dropped.
    assign blocked = hit.start && (host.q == hit.q);

    always_ff @(posedge clk) begin
        if (host.wr && !blocked) begin
            mem[{host.q, host.idx}] <= host.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NQ; i++) begin
                ptr[i] <= '0;
            end
        end else begin
            if (hit.start) begin
                ptr[hit.q] <= ptr[hit.q] + 1'b1;
            end
            if (host.clr && !blocked) begin
                ptr[host.q] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= '0;
        end else if (host.mode_wr && !blocked) begin
            mode_r[host.q] <= host.mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_entry <= '0;
            rd_mode  <= LANE_WIDE;
        end else if (hit.start) begin
            rd_entry <= mem[{hit.q, ptr[hit.q]}];
            rd_mode  <= lane_mode_e'(mode_r[hit.q]);
        end
    end

    // R2
    r2_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        hit.start |=> (ptr[$past(hit.q)] == DEPTH_LG'($past(ptr[hit.q]) + 1'b1)));

    // R9
    r9_mode_kept_chk: assert property (@(posedge clk) disable iff (rst)
        blocked |=> (mode_r == $past(mode_r)));

endmodule

// File: rtl/hsq_lanes.sv
module hsq_lanes
    import hsq_pkg::*;
#(
    parameter int DATA_W  = HSQ_DATA_W,
    parameter int ENTRY_W = HSQ_ENTRY_W,
    parameter int NIB_W   = HSQ_NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               drive_on,
    input  logic               bus_phi2,
    input  logic               bus_rnw,
    input  logic [ENTRY_W-1:0] rd_entry,
    input  lane_mode_e         rd_mode,
    output logic [DATA_W-1:0]  bus_dout,
    output logic [DATA_W-1:0]  bus_doe
);

    localparam int TOP_W = DATA_W - ENTRY_W;

    logic               live;
    logic [ENTRY_W-1:0] payload;

    assign live = drive_on && bus_phi2 && bus_rnw;

    always_comb begin
        payload = rd_entry;
        if (rd_mode == LANE_NIBBLE) begin
            payload[ENTRY_W-1:NIB_W] = '0;
        end
    end

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_lane
            if (b < ENTRY_W) begin : g_own
                assign bus_doe[b]  = live;
                assign bus_dout[b] = live && payload[b];
            end else begin : g_chip
                assign bus_doe[b]  = 1'b0;
                assign bus_dout[b] = 1'b0;
            end
        end
    endgenerate

    // R3
    r3_top_lanes_free_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_doe[DATA_W-1:ENTRY_W] == '0) && (bus_dout[DATA_W-1:ENTRY_W] == '0));

    // R4
    r4_no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rnw |-> (bus_doe == '0));

    // R5
    r5_phase_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_phi2 |-> (bus_doe == '0));

    // R7
    r7_nibble_high_low_chk: assert property (@(posedge clk) disable iff (rst)
        (live && rd_mode == LANE_NIBBLE) |-> (bus_dout[ENTRY_W-1:NIB_W] == '0));

    initial begin
        assert (TOP_W >= 0 && NIB_W <= ENTRY_W);
    end

endmodule

// File: rtl/hotspot_feeder.sv
module hotspot_feeder
    import hsq_pkg::*;
#(
    parameter int ADDR_W   = HSQ_ADDR_W,
    parameter int DATA_W   = HSQ_DATA_W,
    parameter int ENTRY_W  = HSQ_ENTRY_W,
    parameter int NIB_W    = HSQ_NIB_W,
    parameter int NQ_LG    = HSQ_NQ_LG,
    parameter int DEPTH_LG = HSQ_DEPTH_LG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rnw,
    input  logic                bus_phi2,
    output logic [DATA_W-1:0]   bus_dout,
    output logic [DATA_W-1:0]   bus_doe,
    input  logic                host_wr,
    input  logic                host_clr,
    input  logic                host_mode_wr,
    input  logic                host_mode,
    input  logic [NQ_LG-1:0]    host_q,
    input  logic [DEPTH_LG-1:0] host_idx,
    input  logic [ENTRY_W-1:0]  host_data
);

    hit_t               hit;
    host_op_t           host;
    logic               drive_on;
    logic [ENTRY_W-1:0] rd_entry;
    lane_mode_e         rd_mode;

    always_comb begin
        host.wr      = host_wr;
        host.clr     = host_clr;
        host.mode_wr = host_mode_wr;
        host.mode    = lane_mode_e'(host_mode);
        host.q       = host_q;
        host.idx     = host_idx;
        host.data    = host_data;
    end

    hsq_snoop #(
        .ADDR_W (ADDR_W)
    ) snoop_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_rnw  (bus_rnw),
        .bus_phi2 (bus_phi2),
        .hit      (hit),
        .drive_on (drive_on)
    );

    hsq_store #(
        .NQ_LG    (NQ_LG),
        .DEPTH_LG (DEPTH_LG),
        .ENTRY_W  (ENTRY_W)
    ) store_i (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .host     (host),
        .rd_entry (rd_entry),
        .rd_mode  (rd_mode)
    );

    hsq_lanes #(
        .DATA_W  (DATA_W),
        .ENTRY_W (ENTRY_W),
        .NIB_W   (NIB_W)
    ) lanes_i (
        .clk      (clk),
        .rst      (rst),
        .drive_on (drive_on),
        .bus_phi2 (bus_phi2),
        .bus_rnw  (bus_rnw),
        .rd_entry (rd_entry),
        .rd_mode  (rd_mode),
        .bus_dout (bus_dout),
        .bus_doe  (bus_doe)
    );

endmodule

// File: tb/hotspot_feeder_tb.sv
module hotspot_feeder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] bus_addr;
    logic        bus_rnw;
    logic        bus_phi2;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_doe;
    logic        host_wr, host_clr, host_mode_wr, host_mode;
    logic [3:0]  host_q;
    logic [7:0]  host_idx;
    logic [5:0]  host_data;

    always #4 clk = ~clk;

    hotspot_feeder dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_phi2(bus_phi2), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .host_wr(host_wr), .host_clr(host_clr), .host_mode_wr(host_mode_wr),
        .host_mode(host_mode), .host_q(host_q), .host_idx(host_idx),
        .host_data(host_data)
    );

    typedef struct {
        logic [7:0] doe;
        logic [7:0] dout;
        string      req;
    } exp_t;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [5:0] mdl_mem [16][256];
    logic [7:0] mdl_ptr [16];
    logic       mdl_nib [16];
    exp_t       sb [$];
    event       smp_ev;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected item for each sampled access.
    initial begin
        forever begin
            @(smp_ev);
            if (sb.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2 scoreboard empty actual=sample expected=item");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " enables"}, bus_doe, e.doe);
                if (e.doe != 8'h00) check({e.req, " data"}, bus_dout, e.dout);
            end
        end
    end

    task automatic host_load(input logic [3:0] q, input logic [7:0] i, input logic [5:0] d);
        mdl_mem[q][i] = d;
        @(negedge clk);
        host_wr = 1'b1; host_q = q; host_idx = i; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_clear(input logic [3:0] q);
        mdl_ptr[q] = 8'd0;
        @(negedge clk);
        host_clr = 1'b1; host_q = q;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    task automatic host_set_mode(input logic [3:0] q, input logic m);
        mdl_nib[q] = m;
        @(negedge clk);
        host_mode_wr = 1'b1; host_q = q; host_mode = m;
        @(negedge clk);
        host_mode_wr = 1'b0;
    endtask

    // Driver: computes the expected result, pushes it, then runs one bus access.
    task automatic bus_access(input logic [12:0] a, input logic rnw, input string req,
                              input logic do_ld = 1'b0, input logic [3:0] lq = 4'd0,
                              input logic [7:0] li = 8'd0, input logic [5:0] ld = 6'd0,
                              input logic do_clr = 1'b0, input int hold = 2);
        logic       hit;
        logic [3:0] q;
        exp_t       e;
        hit = rnw && !a[12] && !a[7] && (a[3:1] == 3'b111);
        q = {a[6:4], a[0]};
        e.req = req;
        e.doe = hit ? 8'h3F : 8'h00;
        e.dout = 8'h00;
        if (hit) begin
            if (mdl_nib[q]) e.dout = {4'b0, mdl_mem[q][mdl_ptr[q]][3:0]};
            else            e.dout = {2'b0, mdl_mem[q][mdl_ptr[q]]};
            mdl_ptr[q] = mdl_ptr[q] + 8'd1;
        end
        if (!(hit && lq == q)) begin
            if (do_ld)  mdl_mem[lq][li] = ld;
            if (do_clr) mdl_ptr[lq] = 8'd0;
        end
        sb.push_back(e);
        @(negedge clk);
        bus_addr = a; bus_rnw = rnw; bus_phi2 = 1'b1;
        @(negedge clk);
        host_wr = do_ld; host_clr = do_clr; host_q = lq; host_idx = li; host_data = ld;
        @(negedge clk);
        host_wr = 1'b0; host_clr = 1'b0;
        -> smp_ev;
        repeat (hold) @(negedge clk);
        bus_phi2 = 1'b0;
        #1;
        check("R5 enables off once phase is low", bus_doe, 8'h00);
        @(negedge clk);
        bus_rnw = 1'b1; bus_addr = 13'h0000;
        @(negedge clk);
    endtask

    task automatic run_tests();
        logic [7:0] p;
        rst = 1'b1;
        bus_addr = 13'h0000; bus_rnw = 1'b1; bus_phi2 = 1'b0;
        host_wr = 1'b0; host_clr = 1'b0; host_mode_wr = 1'b0; host_mode = 1'b0;
        host_q = 4'd0; host_idx = 8'd0; host_data = 6'd0;
        for (int q = 0; q < 16; q++) begin
            mdl_ptr[q] = 8'd0;
            mdl_nib[q] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 enables off after reset", bus_doe, 8'h00);

        for (int q = 0; q < 16; q++) begin
            for (int i = 0; i < 256; i++) begin
                host_load(4'(q), 8'(i), 6'((q * 7 + i * 5 + 3) & 63));
            end
        end

        // R1 R2 R11: decode, queue selection, pointers start at 0
        bus_access(13'h000E, 1'b1, "R1 R11 queue 0 first entry");
        bus_access(13'h000E, 1'b1, "R2 queue 0 second entry");
        bus_access(13'h000F, 1'b1, "R1 queue 1 at nibble F");
        bus_access(13'h007E, 1'b1, "R1 queue 14");
        bus_access(13'h0F5F, 1'b1, "R1 mirrored A11..A8 to queue 11");
        bus_access(13'h005F, 1'b1, "R1 R2 queue 11 after mirror alias");

        // R6: reads outside the hotspots
        bus_access(13'h002D, 1'b1, "R6 nibble D read");
        bus_access(13'h103E, 1'b1, "R6 A12 high read");
        bus_access(13'h00BE, 1'b1, "R6 A7 high read");
        bus_access(13'h0008, 1'b1, "R6 plain chip read");
        bus_access(13'h003E, 1'b1, "R6 queue 6 pointer untouched");

        // R4: write to a hotspot
        bus_access(13'h001E, 1'b0, "R4 write cycle no drive");
        bus_access(13'h001E, 1'b1, "R4 queue 2 pointer untouched by write");

        // R7: four-bit mode
        host_set_mode(4'd5, 1'b1);
        bus_access(13'h002F, 1'b1, "R7 nibble mode queue 5");
        bus_access(13'h002F, 1'b1, "R7 nibble mode queue 5 next");
        host_set_mode(4'd5, 1'b0);
        bus_access(13'h002F, 1'b1, "R7 back to six-bit mode");

        // R8: host clear and load
        host_clear(4'd0);
        bus_access(13'h000E, 1'b1, "R8 clear rewinds queue 0");
        host_load(4'd0, 8'd1, 6'h2A);
        bus_access(13'h000E, 1'b1, "R8 loaded entry returned");

        // R9: collisions and a non-colliding host op
        p = mdl_ptr[8];
        bus_access(13'h004E, 1'b1, "R9 read wins over load", 1'b1, 4'd8, p + 8'd1, 6'h15);
        bus_access(13'h004E, 1'b1, "R9 dropped load left entry");
        bus_access(13'h004E, 1'b1, "R9 read wins over clear", 1'b0, 4'd8, 8'd0, 6'd0, 1'b1);
        bus_access(13'h004E, 1'b1, "R9 dropped clear left pointer");
        bus_access(13'h004E, 1'b1, "R9 other queue load applies", 1'b1, 4'd9, 8'd0, 6'h33);
        bus_access(13'h004F, 1'b1, "R9 queue 9 shows new entry");

        // R10: a long phase advances once
        bus_access(13'h006E, 1'b1, "R10 long phase", 1'b0, 4'd0, 8'd0, 6'd0, 1'b0, 9);
        bus_access(13'h006E, 1'b1, "R10 next entry only");

        // R2: full lap with wrap on queue 15
        for (int k = 0; k < 257; k++) begin
            bus_access(13'h007F, 1'b1, "R2 wrap lap queue 15");
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule